// File: doc/BRIEF.md
# Byte-Wide Priority Interrupt Controller

This block gathers eight edge-triggered interrupt inputs and resolves them with fixed priority, input 0 highest. Three byte registers hold its state: a pending-request register, an in-service register and a mask register. When an unmasked request is pending and nothing of equal or higher priority is in service, it raises a single interrupt line. A one-cycle acknowledge pulse from the processor side retires the winning request. The block then delivers an 8-bit vector equal to a programmed base plus the input number.

Software programs the block through two byte ports, selected by `addr` (0 is the command port, 1 is the data port). A command write with bit 4 set opens an initialisation sequence of up to four words. Further command writes issue specific end-of-interrupt codes and choose which register command-port reads return. Several controllers can be cascaded. A master drives a 3-bit cascade identifier when it acknowledges an input that has a slave behind it. A slave answers an acknowledge only when that identifier matches its own.

The vector leaves on a valid-only stream: `vec_valid` is high for exactly the one cycle after the accepted acknowledge, and there is no back-pressure. The consumer must capture `vec` in that cycle. Reads are free of side effects: `rdata` follows `addr` combinationally.

Top module: `pic_core`

## Requirements
- R1: After reset, and in the cycle after any command write with bit 4 set, the mask, pending and in-service registers all read 0 and command-port reads return the pending register.
- R2: A command write with bit 4 set starts initialisation. The next three data writes are taken, in order, as the vector base, the cascade word and the mode word; the mode word is skipped when bit 0 of the start word was clear. Data writes after that go to the mask register.
- R3: The accepted acknowledge of input n, when it is not routed to a slave, gives `vec_valid` high in the next cycle with `vec` equal to base + n.
- R4: Priority is fixed, with input 0 highest. `int_out` is high only while some pending unmasked input has a lower number than every set in-service bit.
- R5: A rising edge on an input sets its pending bit. The bit clears when that input is acknowledged, or as soon as the input falls before acknowledge.
- R6: Data-port reads and writes outside initialisation access the mask register. A 1 in bit n keeps input n from raising `int_out`.
- R7: When bit 1 of the mode word is 1 (automatic end of interrupt), an acknowledge sets no in-service bit.
- R8: A command write of 0x60 + n (n from 0 to 7) clears in-service bit n and no other bit.
- R9: A command write of 0x0A selects the pending register for command-port reads, and 0x0B selects the in-service register. The choice holds until the next such write.
- R10: An accepted acknowledge with no eligible request returns base + 7 and changes no in-service bit, even while input 7 is masked.
- R11: On a master (`is_master` = 1), acknowledging an input whose bit is set in the cascade word drives `cas_out` = n with `cas_oe` high during the acknowledge cycle, and the master raises no `vec_valid`.
- R12: On a slave (`is_master` = 0), an acknowledge is accepted only when `cas_in` equals bits 2:0 of the cascade word. Otherwise it produces no vector and leaves the pending register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 1 | 0 selects the command port, 1 the data port |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the selected port |
| irq_in | input | 8 | Interrupt request inputs |
| is_master | input | 1 | 1 makes this controller a master, 0 a slave |
| ack | input | 1 | One-cycle interrupt acknowledge |
| cas_in | input | 3 | Cascade identifier seen by a slave |
| int_out | output | 1 | Interrupt request to the processor |
| vec_valid | output | 1 | Vector valid, one cycle, no back-pressure |
| vec | output | 8 | Interrupt vector |
| cas_out | output | 3 | Cascade identifier driven by a master |
| cas_oe | output | 1 | Enable for `cas_out` |

## Verification
The bench targets the places where priority and in-service state interact. A lower-priority request must stay hidden behind an in-service bit and reappear after a specific EOI; a design that compares against the wrong ISR bound would interrupt a running handler. It drops a request before acknowledge and checks for vector base + 7 with the ISR untouched, also while input 7 is masked; a design that latches edges with no level check would return a stale vector or set a bogus ISR bit. It also checks the cascade rules: a master acknowledging a slave-marked input must put out the identifier and no vector of its own. A slave given a foreign identifier must not consume its pending request.

// File: rtl/pic_pkg.sv
package pic_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_BASE = 2'd1,
    ST_CASC = 2'd2,
    ST_MODE = 2'd3
  } init_st_e;
endpackage

// File: rtl/pic_init_ctl.sv
module pic_init_ctl
  import pic_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_wr,
  input  logic          data_wr,
  input  logic [DW-1:0] wdata,
  output logic          init_start,
  output logic          imr_wr,
  output logic          running,
  output logic [DW-1:0] base,
  output logic [DW-1:0] casc,
  output logic          aeoi
);
  init_st_e st_q;
  logic     want_mode_q;

  assign init_start = cmd_wr & wdata[4];
  assign running    = (st_q == ST_RUN);
  assign imr_wr     = data_wr & running;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_RUN;
      want_mode_q <= 1'b0;
      base        <= '0;
      casc        <= '0;
      aeoi        <= 1'b0;
    end else if (init_start) begin
      st_q        <= ST_BASE;
      want_mode_q <= wdata[0];
    end else if (data_wr) begin
      unique case (st_q)
        ST_BASE: begin
          base <= wdata;
          st_q <= ST_CASC;
        end
        ST_CASC: begin
          casc <= wdata;
          if (want_mode_q) st_q <= ST_MODE;
          else begin
            aeoi <= 1'b0;
            st_q <= ST_RUN;
          end
        end
        ST_MODE: begin
          aeoi <= wdata[1];
          st_q <= ST_RUN;
        end
        default: st_q <= ST_RUN;
      endcase
    end
  end
endmodule

// File: rtl/pic_prio.sv
module pic_prio #(
  parameter int N_IN = 8,
  localparam int IDW = $clog2(N_IN)
) (
  input  logic [N_IN-1:0] req,
  input  logic [N_IN-1:0] isr,
  output logic            eligible,
  output logic [IDW-1:0]  win
);
  logic         any_req;
  logic [IDW:0] isr_top;

  always_comb begin
    any_req = 1'b0;
    win     = '0;
    isr_top = (IDW+1)'(N_IN);
    for (int i = N_IN - 1; i >= 0; i--) begin
      if (req[i]) begin
        any_req = 1'b1;
        win     = i[IDW-1:0];
      end
      if (isr[i]) isr_top = i[IDW:0];
    end
    eligible = any_req && ({1'b0, win} < isr_top);
  end
endmodule

// File: rtl/pic_core.sv
module pic_core #(
  parameter int N_IN = 8,
  parameter int DW   = 8,
  localparam int IDW = $clog2(N_IN)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic            addr,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   rdata,
  input  logic [N_IN-1:0] irq_in,
  input  logic            is_master,
  input  logic            ack,
  input  logic [IDW-1:0]  cas_in,
  output logic            int_out,
  output logic            vec_valid,
  output logic [DW-1:0]   vec,
  output logic [IDW-1:0]  cas_out,
  output logic            cas_oe
);
  logic            cmd_wr, data_wr;
  logic            init_start, imr_wr, running, aeoi;
  logic [DW-1:0]   base, casc;
  logic [N_IN-1:0] irr_q, isr_q, imr_q, irq_q;
  logic            rsel_q;
  logic            eligible;
  logic [IDW-1:0]  win;
  logic            selected, take, to_slave, eoi_wr, sel_wr;
  logic [N_IN-1:0] rise, win_mask, ack_clr, eoi_mask;

  assign cmd_wr  = wr_en & ~addr;
  assign data_wr = wr_en & addr;

  pic_init_ctl #(.DW(DW)) u_init (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .data_wr(data_wr),
    .wdata(wdata), .init_start(init_start), .imr_wr(imr_wr),
    .running(running), .base(base), .casc(casc), .aeoi(aeoi)
  );

  pic_prio #(.N_IN(N_IN)) u_prio (
    .req(irr_q & ~imr_q), .isr(isr_q), .eligible(eligible), .win(win)
  );

  assign rise     = irq_in & ~irq_q;
  assign win_mask = N_IN'(1) << win;
  assign selected = is_master | (cas_in == casc[IDW-1:0]);
  assign take     = ack & selected & running;
  assign to_slave = is_master & eligible & casc[win];
  assign ack_clr  = (take & eligible) ? win_mask : '0;

  assign eoi_wr   = cmd_wr & running & ~wdata[4] & ~wdata[3] & (wdata[7:5] == 3'b011);
  assign eoi_mask = eoi_wr ? (N_IN'(1) << wdata[IDW-1:0]) : '0;
  assign sel_wr   = cmd_wr & ~wdata[4] & wdata[3] & wdata[1];

  assign int_out = eligible & running;
  assign cas_oe  = take & to_slave;
  assign cas_out = cas_oe ? win : '0;
  assign rdata   = addr ? DW'(imr_q) : (rsel_q ? DW'(isr_q) : DW'(irr_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= '0;
      irr_q <= '0;
      isr_q <= '0;
      imr_q <= '0;
      rsel_q <= 1'b0;
    end else begin
      irq_q <= irq_in;
      if (init_start) begin
        irr_q  <= '0;
        isr_q  <= '0;
        imr_q  <= '0;
        rsel_q <= 1'b0;
      end else begin
        irr_q <= (irr_q & irq_in & ~ack_clr) | rise;
        isr_q <= (isr_q & ~eoi_mask) | ((aeoi) ? '0 : ack_clr);
        if (imr_wr) imr_q <= wdata[N_IN-1:0];
        if (sel_wr) rsel_q <= wdata[0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_valid <= 1'b0;
      vec       <= '0;
    end else begin
      vec_valid <= take & ~to_slave;
      if (take) vec <= base + (eligible ? DW'(win) : DW'(N_IN - 1));
    end
  end
endmodule

// File: rtl/pic_core_chk.sv
module pic_core_chk #(
  parameter int N_IN = 8,
  parameter int DW   = 8,
  localparam int IDW = $clog2(N_IN)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_en,
  input logic            addr,
  input logic [DW-1:0]   wdata,
  input logic            is_master,
  input logic            ack,
  input logic [IDW-1:0]  cas_in,
  input logic            int_out,
  input logic            vec_valid,
  input logic            cas_oe,
  input logic [N_IN-1:0] irr,
  input logic [N_IN-1:0] isr,
  input logic [N_IN-1:0] imr,
  input logic [DW-1:0]   casc,
  input logic            aeoi
);
  p_int_needs_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
    int_out |-> ((irr & ~imr) != '0));

  p_vec_after_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> $past(ack));

  p_cas_master_only_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cas_oe |-> (is_master && ack));

  p_init_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !addr && wdata[4]) |=> (imr == '0 && isr == '0 && irr == '0));

  p_aeoi_no_isr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (aeoi && ack && !wr_en) |=> (isr == $past(isr)));

  p_slave_ignores_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_master && ack && !wr_en && cas_in != casc[IDW-1:0]) |=> !vec_valid);
endmodule

bind pic_core pic_core_chk #(.N_IN(N_IN), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .is_master(is_master), .ack(ack), .cas_in(cas_in), .int_out(int_out),
  .vec_valid(vec_valid), .cas_oe(cas_oe), .irr(irr_q), .isr(isr_q),
  .imr(imr_q), .casc(casc), .aeoi(aeoi)
);

// File: tb/pic_core_bench.sv
module pic_core_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic       addr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [7:0] irq_in = '0;
  logic       is_master = 1'b1;
  logic       ack = 1'b0;
  logic [2:0] cas_in = '0;
  logic       int_out, vec_valid, cas_oe;
  logic [7:0] vec;
  logic [2:0] cas_out;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pic_core u_pic_core (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq_in(irq_in), .is_master(is_master), .ack(ack),
    .cas_in(cas_in), .int_out(int_out), .vec_valid(vec_valid), .vec(vec),
    .cas_out(cas_out), .cas_oe(cas_oe)
  );

  // op codes: 0 write, 1 read check, 2 set irq_in, 3 check int_out,
  //           4 ack expecting vector, 5 ack expecting cascade id
  localparam int NV = 43;
  localparam logic [23:0] TBL [NV] = '{
    {4'd2, 3'd0, 1'b0, 8'h11, 8'h00},  // R2 start init
    {4'd2, 3'd0, 1'b1, 8'h20, 8'h00},  // R2 base
    {4'd2, 3'd0, 1'b1, 8'h04, 8'h00},  // R2 input 2 has slave
    {4'd2, 3'd0, 1'b1, 8'h01, 8'h00},  // R2 mode, normal EOI
    {4'd1, 3'd1, 1'b1, 8'h00, 8'h00},  // R1 mask clear
    {4'd1, 3'd1, 1'b0, 8'h00, 8'h00},  // R1 pending clear
    {4'd6, 3'd0, 1'b1, 8'hF0, 8'h00},  // R6 mask write
    {4'd6, 3'd1, 1'b1, 8'h00, 8'hF0},  // R6 mask read
    {4'd5, 3'd2, 1'b0, 8'h08, 8'h00},  // R5 edge on input 3
    {4'd5, 3'd3, 1'b0, 8'h00, 8'h01},  // R5
    {4'd5, 3'd1, 1'b0, 8'h00, 8'h08},  // R5 pending reads 0x08
    {4'd4, 3'd2, 1'b0, 8'h09, 8'h00},  // R4 add input 0
    {4'd4, 3'd4, 1'b0, 8'h00, 8'h20},  // R4 input 0 wins, R3 vector
    {4'd4, 3'd3, 1'b0, 8'h00, 8'h00},  // R4 blocked by ISR0
    {4'd9, 3'd0, 1'b0, 8'h0B, 8'h00},  // R9 select ISR
    {4'd9, 3'd1, 1'b0, 8'h00, 8'h01},  // R9
    {4'd9, 3'd1, 1'b0, 8'h00, 8'h01},  // R9 persists
    {4'd8, 3'd0, 1'b0, 8'h60, 8'h00},  // R8 EOI level 0
    {4'd8, 3'd1, 1'b0, 8'h00, 8'h00},  // R8
    {4'd4, 3'd3, 1'b0, 8'h00, 8'h01},  // R4 input 3 now eligible
    {4'd3, 3'd4, 1'b0, 8'h00, 8'h23},  // R3 vector base+3
    {4'd11, 3'd2, 1'b0, 8'h0D, 8'h00}, // R11 edge on cascade input 2
    {4'd4, 3'd3, 1'b0, 8'h00, 8'h01},  // R4 2 beats ISR3
    {4'd11, 3'd5, 1'b0, 8'h02, 8'h00}, // R11 cascade id 2
    {4'd11, 3'd1, 1'b0, 8'h00, 8'h0C}, // R11 ISR has 2 and 3
    {4'd8, 3'd0, 1'b0, 8'h62, 8'h00},  // R8 EOI level 2
    {4'd8, 3'd1, 1'b0, 8'h00, 8'h08},  // R8 only bit 2 cleared
    {4'd5, 3'd2, 1'b0, 8'h00, 8'h00},  // drop all inputs
    {4'd6, 3'd0, 1'b1, 8'h02, 8'h00},  // R6 mask input 1
    {4'd6, 3'd2, 1'b0, 8'h02, 8'h00},  // R6 edge on input 1
    {4'd6, 3'd3, 1'b0, 8'h00, 8'h00},  // R6 masked, no int
    {4'd9, 3'd0, 1'b0, 8'h0A, 8'h00},  // R9 select pending
    {4'd9, 3'd1, 1'b0, 8'h00, 8'h02},  // R9 pending 0x02
    {4'd6, 3'd0, 1'b1, 8'h00, 8'h00},  // R6 unmask
    {4'd6, 3'd3, 1'b0, 8'h00, 8'h01},  // R6 int raised
    {4'd5, 3'd2, 1'b0, 8'h00, 8'h00},  // R5 input falls early
    {4'd5, 3'd1, 1'b0, 8'h00, 8'h00},  // R5 pending cleared
    {4'd10, 3'd3, 1'b0, 8'h00, 8'h00}, // R10 no int
    {4'd10, 3'd4, 1'b0, 8'h00, 8'h27}, // R10 spurious vector
    {4'd10, 3'd0, 1'b0, 8'h0B, 8'h00}, // R10 select ISR
    {4'd10, 3'd1, 1'b0, 8'h00, 8'h08}, // R10 ISR unchanged
    {4'd10, 3'd0, 1'b1, 8'h80, 8'h00}, // R10 mask input 7
    {4'd10, 3'd4, 1'b0, 8'h00, 8'h27}  // R10 spurious while masked
  };

  task automatic chk(input bit ok, input int req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL R%0d actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_rd(input logic a, input logic [7:0] e, input int req);
    @(negedge clk);
    addr = a;
    #1 chk(rdata == e, req, rdata, e);
  endtask

  task automatic do_irq(input logic [7:0] d);
    @(negedge clk);
    irq_in = d;
    @(negedge clk);
  endtask

  task automatic do_ack(input logic [7:0] e, input int req);
    @(negedge clk);
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    #1 chk(vec_valid && vec == e, req, {vec_valid, vec}, {1'b1, e});
  endtask

  task automatic do_ack_cas(input logic [2:0] id, input int req);
    @(negedge clk);
    ack = 1'b1;
    #1 chk(cas_oe && cas_out == id, req, {cas_oe, cas_out}, {1'b1, id});
    @(negedge clk);
    ack = 1'b0;
    #1 chk(!vec_valid, req, vec_valid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    do_rd(1'b1, 8'h00, 1);
    do_rd(1'b0, 8'h00, 1);
    #1 chk(!int_out && !vec_valid, 1, int_out, 0);

    for (int i = 0; i < NV; i++) begin
      automatic logic [3:0] rq = TBL[i][23:20];
      automatic logic [2:0] op = TBL[i][19:17];
      automatic logic       a  = TBL[i][16];
      automatic logic [7:0] d  = TBL[i][15:8];
      automatic logic [7:0] e  = TBL[i][7:0];
      case (op)
        3'd0: do_wr(a, d);
        3'd1: do_rd(a, e, rq);
        3'd2: do_irq(d);
        3'd3: #1 chk(int_out == e[0], rq, int_out, e[0]);
        3'd4: do_ack(e, rq);
        default: do_ack_cas(d[2:0], rq);
      endcase
    end

    // R7 automatic EOI, new base; R1 re-init clears mask
    do_wr(1'b0, 8'h11);
    do_wr(1'b1, 8'h40);
    do_wr(1'b1, 8'h00);
    do_wr(1'b1, 8'h03);
    do_rd(1'b1, 8'h00, 1);
    do_irq(8'h20);
    do_ack(8'h45, 3);
    do_wr(1'b0, 8'h0B);
    do_rd(1'b0, 8'h00, 7);
    do_wr(1'b0, 8'h0A);
    do_rd(1'b0, 8'h00, 5);

    // R12 slave with id 2
    do_irq(8'h00);
    is_master = 1'b0;
    do_wr(1'b0, 8'h11);
    do_wr(1'b1, 8'h70);
    do_wr(1'b1, 8'h02);
    do_wr(1'b1, 8'h01);
    do_irq(8'h10);
    cas_in = 3'd3;
    @(negedge clk);
    ack = 1'b1;
    #1 chk(!cas_oe, 12, cas_oe, 0);
    @(negedge clk);
    ack = 1'b0;
    #1 chk(!vec_valid, 12, vec_valid, 0);
    do_rd(1'b0, 8'h10, 12);
    cas_in = 3'd2;
    do_ack(8'h74, 12);
    do_rd(1'b0, 8'h00, 12);

    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule